// File: doc/BRIEF.md
# Timer Compare Channel

This block is one output channel of a general-purpose timer. It watches a counter value that is shared with the other channels and arrives with an up/down direction flag. It compares that value against a programmable compare value and builds an internal, active-high reference level. A 3-bit mode field selects how the level is built. The available behaviours are:

- hold the level;
- set, clear or toggle the level on equality;
- force the level low or high;
- run one of two pulse-width modes, whose meaning depends on the count direction.

An external clear line, when armed, drives the level low.

Software loads the channel through two write strobes. The first loads the control fields. The second loads the compare value, which can go through a shadow register that is copied on an update event. The channel drives a main output and a complementary output. Each output applies its own polarity bit to the reference level. Both outputs rest at their polarity level when the channel is disabled or is configured as an input.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset, ref_o is 0, sel_o is 00, cmp_o is 0, and out_main and out_comp are 0. At reset the mode is 000, and the clear, shadow, enable and polarity bits are all 0.
- R2: With mode 000 the reference holds its previous value for any counter value.
- R3: Mode 001 sets the reference to 1, and mode 010 clears it to 0, in the cycle after cnt_val equals cmp_o. At other counter values the reference is left unchanged.
- R4: With mode 011 the reference inverts in the cycle after each cycle where cnt_val equals cmp_o.
- R5: Mode 100 drives the reference to 0 and mode 101 drives it to 1 one cycle later, whatever the counter is.
- R6: In mode 110 with cnt_dn=0, the reference becomes (cnt_val < cmp_o). In mode 110 with cnt_dn=1, it becomes (cnt_val <= cmp_o).
- R7: Mode 111 gives the inverse of the mode 110 level in both count directions.
- R8: In modes 110 and 111 the reference is reloaded only in two cases: when the raw comparison result changed from the previous cycle, or when the previous cycle's mode was 000. Entering a PWM mode from a forced mode with a steady counter leaves the reference unchanged.
- R9: When ctl_clr_en is 1 and ext_clr is 1, the reference goes to 0 on the next edge, whatever the mode. When ctl_clr_en is 0, ext_clr has no effect.
- R10: When the channel is enabled and sel_o is 00, out_main equals ref_o XOR pol_main and out_comp equals (NOT ref_o) XOR pol_comp. Otherwise out_main equals pol_main and out_comp equals pol_comp.
- R11: A control write updates sel_o only if the enable bit was 0 before the write. The other control fields are always written.
- R12: With shadow disabled, a compare write reaches cmp_o on the next edge. With shadow enabled, a compare write goes only to the shadow register, and upd_evt copies the shadow register to cmp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CW | Shared counter value |
| cnt_dn | input | 1 | 1 when the counter is counting down |
| upd_evt | input | 1 | Update event; loads the shadow compare value |
| ext_clr | input | 1 | External clear request |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 3 | Compare mode code |
| ctl_clr_en | input | 1 | Arms the external clear |
| ctl_shadow_en | input | 1 | Routes compare writes through the shadow register |
| ctl_chan_en | input | 1 | Channel enable |
| ctl_sel | input | 2 | Channel selection: 00 output, 01/10/11 input sources |
| ctl_pol_main | input | 1 | Main output polarity |
| ctl_pol_comp | input | 1 | Complementary output polarity |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value write data |
| ref_o | output | 1 | Internal reference level |
| out_main | output | 1 | Polarity-adjusted main output |
| out_comp | output | 1 | Polarity-adjusted complementary output |
| sel_o | output | 2 | Current channel selection |
| cmp_o | output | CW | Active compare value |

## Verification
The counter is driven in three patterns: an up-count sweep that wraps, a down-count sweep that wraps, and a held value. The sweeps exercise each equality mode repeatedly. In the pulse-width modes, the two sweep directions separate the strict-less rule from the less-or-equal rule at the compare value itself. The held counter separates the rule that reloads the level on a comparison edge from one that reloads it every cycle, and a switch out of mode 000 must still force a reload. The clear line is raised with the arm bit set and cleared, and the selection write is tried with the channel enabled and disabled.

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_dn,
  input  logic          upd_evt,
  input  logic          ext_clr,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_clr_en,
  input  logic          ctl_shadow_en,
  input  logic          ctl_chan_en,
  input  logic [1:0]    ctl_sel,
  input  logic          ctl_pol_main,
  input  logic          ctl_pol_comp,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic          ref_o,
  output logic          out_main,
  output logic          out_comp,
  output logic [1:0]    sel_o,
  output logic [CW-1:0] cmp_o
);

  localparam logic [2:0] M_HOLD = 3'b000;
  localparam logic [2:0] M_SET  = 3'b001;
  localparam logic [2:0] M_CLR  = 3'b010;
  localparam logic [2:0] M_TOG  = 3'b011;
  localparam logic [2:0] M_LOW  = 3'b100;
  localparam logic [2:0] M_HIGH = 3'b101;

  logic [2:0]    mode_q, mode_prev_q;
  logic          clr_en_q, shadow_q, en_q, pm_q, pc_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] act_q, pre_q;
  logic          ref_q, raw_q, ref_d;

  wire eq      = (cnt_val == act_q);
  wire raw     = cnt_dn ? (cnt_val <= act_q) : (cnt_val < act_q);
  wire pwm_lvl = raw ^ mode_q[0];
  wire pwm_go  = (raw != raw_q) || (mode_prev_q == M_HOLD);
  wire clr_hit = clr_en_q && ext_clr;
  wire drive   = en_q && (sel_q == 2'b00);

  always_comb begin
    ref_d = ref_q;
    if (clr_hit) ref_d = 1'b0;
    else begin
      case (mode_q)
        M_HOLD: ref_d = ref_q;
        M_SET:  if (eq) ref_d = 1'b1;
        M_CLR:  if (eq) ref_d = 1'b0;
        M_TOG:  if (eq) ref_d = ~ref_q;
        M_LOW:  ref_d = 1'b0;
        M_HIGH: ref_d = 1'b1;
        default: if (pwm_go) ref_d = pwm_lvl;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_HOLD;
      mode_prev_q <= M_HOLD;
      clr_en_q    <= 1'b0;
      shadow_q    <= 1'b0;
      en_q        <= 1'b0;
      pm_q        <= 1'b0;
      pc_q        <= 1'b0;
      sel_q       <= 2'b00;
      act_q       <= '0;
      pre_q       <= '0;
      ref_q       <= 1'b0;
      raw_q       <= 1'b0;
    end else begin
      mode_prev_q <= mode_q;
      raw_q       <= raw;
      ref_q       <= ref_d;
      if (ctl_we) begin
        mode_q   <= ctl_mode;
        clr_en_q <= ctl_clr_en;
        shadow_q <= ctl_shadow_en;
        en_q     <= ctl_chan_en;
        pm_q     <= ctl_pol_main;
        pc_q     <= ctl_pol_comp;
        if (!en_q) sel_q <= ctl_sel;
      end
      if (cmp_we) pre_q <= cmp_wdata;
      if (cmp_we && !shadow_q) act_q <= cmp_wdata;
      else if (upd_evt && shadow_q) act_q <= pre_q;
    end
  end

  assign ref_o    = ref_q;
  assign sel_o    = sel_q;
  assign cmp_o    = act_q;
  assign out_main = drive ? (ref_q ^ pm_q) : pm_q;
  assign out_comp = drive ? (~ref_q ^ pc_q) : pc_q;

  // R2
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOLD && !clr_hit) |=> $stable(ref_o));

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOW) |=> !ref_o);

  // R5
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HIGH && !clr_hit) |=> ref_o);

  // R9
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !ref_o);

  // R11
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(sel_o));

  // R12
  direct_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !shadow_q) |=> (cmp_o == $past(cmp_wdata)));

endmodule

// File: tb/tmr_cmp_chan_tb_top.sv
module tmr_cmp_chan_tb_top;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_val = 0, cmp_wdata = 0;
  logic cnt_dn = 0, upd_evt = 0, ext_clr = 0, ctl_we = 0, cmp_we = 0;
  logic [2:0] ctl_mode = 0;
  logic ctl_clr_en = 0, ctl_shadow_en = 0, ctl_chan_en = 0, ctl_pol_main = 0, ctl_pol_comp = 0;
  logic [1:0] ctl_sel = 0;
  logic ref_o, out_main, out_comp;
  logic [1:0] sel_o;
  logic [CW-1:0] cmp_o;

  always #10 clk = ~clk;

  tmr_cmp_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_dn(cnt_dn), .upd_evt(upd_evt),
    .ext_clr(ext_clr), .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_clr_en(ctl_clr_en),
    .ctl_shadow_en(ctl_shadow_en), .ctl_chan_en(ctl_chan_en), .ctl_sel(ctl_sel),
    .ctl_pol_main(ctl_pol_main), .ctl_pol_comp(ctl_pol_comp), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .ref_o(ref_o), .out_main(out_main), .out_comp(out_comp),
    .sel_o(sel_o), .cmp_o(cmp_o));

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";
  int cnt_pat = 0;

  // behavioural reference model
  int m_mode, m_mode_prev, m_sel, m_act, m_pre;
  bit m_clr, m_sh, m_en, m_pm, m_pc, m_ref, m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_mode_prev = 0; m_sel = 0; m_act = 0; m_pre = 0;
      m_clr = 0; m_sh = 0; m_en = 0; m_pm = 0; m_pc = 0; m_ref = 0; m_raw = 0;
    end else begin
      int c;
      bit rnow, nref, eqm;
      c = int'(cnt_val);
      eqm = (c == m_act);
      rnow = cnt_dn ? (c <= m_act) : (c < m_act);
      nref = m_ref;
      if (m_clr && ext_clr) nref = 0;
      else if (m_mode == 1 && eqm) nref = 1;
      else if (m_mode == 2 && eqm) nref = 0;
      else if (m_mode == 3 && eqm) nref = !m_ref;
      else if (m_mode == 4) nref = 0;
      else if (m_mode == 5) nref = 1;
      else if (m_mode >= 6 && (rnow != m_raw || m_mode_prev == 0))
        nref = (m_mode == 7) ? !rnow : rnow;
      m_mode_prev = m_mode;
      m_raw = rnow;
      m_ref = nref;
      if (ctl_we) begin
        if (!m_en) m_sel = int'(ctl_sel);
        m_mode = int'(ctl_mode); m_clr = ctl_clr_en; m_sh = ctl_shadow_en;
        m_en = ctl_chan_en; m_pm = ctl_pol_main; m_pc = ctl_pol_comp;
      end
      if (cmp_we && !m_sh) begin m_act = int'(cmp_wdata); m_pre = int'(cmp_wdata); end
      else begin
        if (upd_evt && m_sh) m_act = m_pre;
        if (cmp_we) m_pre = int'(cmp_wdata);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      bit drv, em, ec;
      drv = m_en && (m_sel == 0);
      em = drv ? (m_ref ^ m_pm) : m_pm;
      ec = drv ? (!m_ref ^ m_pc) : m_pc;
      chk({phase, " ref"}, int'(ref_o), int'(m_ref));
      chk({"R10 out_main in ", phase}, int'(out_main), int'(em));
      chk({"R10 out_comp in ", phase}, int'(out_comp), int'(ec));
      chk({"R11 sel in ", phase}, int'(sel_o), m_sel);
      chk({"R12 cmp in ", phase}, int'(cmp_o), m_act);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      ctl_we = 0; cmp_we = 0; upd_evt = 0;
      if (cnt_pat == 1) cnt_val = (cnt_val >= 9) ? 0 : cnt_val + 1;
      else if (cnt_pat == 2) cnt_val = (cnt_val == 0) ? 9 : cnt_val - 1;
    end
  endtask

  task automatic wr_ctl(int mode, bit clr, bit sh, bit en, int sel, bit pm, bit pc);
    @(negedge clk);
    ctl_mode = 3'(mode); ctl_clr_en = clr; ctl_shadow_en = sh; ctl_chan_en = en;
    ctl_sel = 2'(sel); ctl_pol_main = pm; ctl_pol_comp = pc; ctl_we = 1;
    step(1);
  endtask

  task automatic wr_cmp(int v);
    @(negedge clk);
    cmp_wdata = CW'(v); cmp_we = 1;
    step(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 ref", int'(ref_o), 0);
    chk("R1 out_main", int'(out_main), 0);
    chk("R1 out_comp", int'(out_comp), 0);
    chk("R1 sel", int'(sel_o), 0);
    chk("R1 cmp", int'(cmp_o), 0);

    phase = "R2"; cnt_pat = 1;
    wr_cmp(5); step(12);
    wr_ctl(5, 0, 0, 1, 0, 0, 0); step(2);
    wr_ctl(0, 0, 0, 1, 0, 0, 0); step(12);
    chk("R2 held high", int'(ref_o), 1);

    phase = "R3";
    wr_ctl(2, 0, 0, 1, 0, 0, 0); step(12);
    chk("R3 cleared on match", int'(ref_o), 0);
    wr_ctl(1, 0, 0, 1, 0, 1, 0); step(12);
    chk("R3 set on match", int'(ref_o), 1);

    phase = "R4";
    wr_ctl(3, 0, 0, 1, 0, 0, 1); step(25);
    cnt_pat = 2; step(25);

    phase = "R5";
    wr_ctl(4, 0, 0, 1, 0, 0, 0); step(3);
    chk("R5 force low", int'(ref_o), 0);
    wr_ctl(5, 0, 0, 1, 0, 0, 0); step(3);
    chk("R5 force high", int'(ref_o), 1);

    phase = "R6"; wr_cmp(4);
    wr_ctl(0, 0, 0, 1, 0, 0, 0); step(1);
    wr_ctl(6, 0, 0, 1, 0, 0, 0);
    cnt_pat = 1; step(22);
    cnt_pat = 2; step(22);

    phase = "R7";
    wr_ctl(7, 0, 0, 1, 0, 1, 1);
    cnt_pat = 1; step(22);
    cnt_pat = 2; step(22);

    phase = "R8"; cnt_pat = 0; cnt_val = 9; cnt_dn = 0;
    wr_ctl(5, 0, 0, 1, 0, 0, 0); step(2);
    wr_ctl(6, 0, 0, 1, 0, 0, 0); step(4);
    chk("R8 no reload on steady compare", int'(ref_o), 1);
    wr_ctl(0, 0, 0, 1, 0, 0, 0); step(1);
    wr_ctl(6, 0, 0, 1, 0, 0, 0); step(2);
    chk("R8 reload after timing", int'(ref_o), 0);

    phase = "R9"; cnt_pat = 1;
    wr_ctl(5, 1, 0, 1, 0, 0, 0); step(2);
    @(negedge clk); ext_clr = 1; step(4);
    chk("R9 cleared", int'(ref_o), 0);
    wr_ctl(5, 0, 0, 1, 0, 0, 0); step(3);
    chk("R9 clear ignored when disarmed", int'(ref_o), 1);
    wr_ctl(6, 1, 0, 1, 0, 0, 0); step(6);
    @(negedge clk); ext_clr = 0; step(22);

    phase = "R10";
    wr_ctl(5, 0, 0, 1, 0, 1, 0); step(2);
    chk("R10 main active-low pol", int'(out_main), 0);
    chk("R10 comp", int'(out_comp), 0);
    wr_ctl(5, 0, 0, 0, 0, 1, 1); step(2);
    chk("R10 idle main", int'(out_main), 1);

    phase = "R11";
    wr_ctl(5, 0, 0, 0, 2, 0, 0); step(1);
    chk("R11 sel written while disabled", int'(sel_o), 2);
    wr_ctl(5, 0, 0, 1, 1, 0, 0); step(1);
    wr_ctl(5, 0, 0, 1, 3, 0, 0); step(2);
    chk("R11 sel locked while enabled", int'(sel_o), 1);
    chk("R10 input mode idle", int'(out_main), 0);
    wr_ctl(5, 0, 0, 0, 0, 0, 0); step(1);
    wr_ctl(5, 0, 0, 0, 0, 0, 0); step(1);
    chk("R11 sel back to output", int'(sel_o), 0);

    phase = "R12";
    wr_ctl(6, 0, 1, 1, 0, 0, 0);
    wr_cmp(7); step(3);
    chk("R12 shadow holds", int'(cmp_o), 4);
    @(negedge clk); upd_evt = 1; step(1);
    chk("R12 update copies", int'(cmp_o), 7);
    step(22);
    wr_ctl(6, 0, 0, 1, 0, 0, 0);
    wr_cmp(2);
    chk("R12 direct write", int'(cmp_o), 2);
    step(22);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule